// File: doc/BRIEF.md
# Flag-Setting Integer ALU

This block is the arithmetic and logic stage of a small RISC datapath. It takes two operands and a three-bit operation code and returns, in the same cycle, the result of an addition, a subtraction or a bitwise operation. Alongside the result it forms four condition flags: negative, zero, carry and overflow. It also decides whether the result should be written back.

A registered flags holder keeps the flags for later conditional instructions. The caller chooses whether an ordinary operation updates that holder. The compare operation always updates the flags and never writes its result. Subtraction is computed as A + ~B + 1, so a set carry after a subtraction means that no borrow occurred.

Top module: `alu_flag_core`

## Requirements
- R1: Operation codes on `op_i` are 0 add, 1 subtract, 2 AND, 3 OR, 4 XOR, 5 bit-clear, 6 move-not and 7 compare. Add returns A+B modulo 2^32. Its carry is the unsigned carry out of bit 31, and its overflow is set when both operands have the same sign and the sum's sign differs.
- R2: Subtract and compare compute A + ~B + 1. Carry is 1 exactly when A >= B unsigned (no borrow). Overflow is set when the operand signs differ and the difference's sign differs from A's.
- R3: AND returns A&B, OR returns A|B, XOR returns A^B, bit-clear returns A&~B and move-not returns ~B.
- R4: When flags are written, N takes bit 31 of the result and Z is 1 exactly when all result bits are 0.
- R5: A flag write by a logical operation (codes 2 to 6) leaves C and V at their previous values.
- R6: Compare writes all four flags regardless of `set_flags_i`, and drives `res_we_o` low regardless of `res_en_i`.
- R7: For any operation other than compare, the flags keep their value on a clock edge where `set_flags_i` is low.
- R8: For any operation other than compare, `res_we_o` equals `res_en_i`.
- R9: After reset `flags_o` is all zeros. Flags change only on a rising clock edge and appear on `flags_o` as {N,Z,C,V} in bits 3 down to 0.
- R10: Comparing 17 with 23 leaves `flags_o` = 4'b1000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| op_i | input | 3 | Operation code |
| a_i | input | 32 | First operand |
| b_i | input | 32 | Second operand |
| set_flags_i | input | 1 | Flag update request for non-compare operations |
| res_en_i | input | 1 | Result write request |
| result_o | output | 32 | Combinational result |
| res_we_o | output | 1 | Result write enable toward the register file |
| flags_o | output | 4 | Registered flags {N,Z,C,V} |

## Verification
On every cycle, the assertions check three things: that flags hold when no update is requested, that compare never writes a result, and that logical operations keep C and V. They also check that N and Z track the result that was just registered. Only the bench's scenarios can show the numerical truth of the results and of carry and overflow. For that, the bench sweeps every operation over a grid of corner operands and a pseudo-random stream, with both enable settings, and compares against arithmetic worked out in the bench. The bench also covers the 17-versus-23 compare.

// File: rtl/alu_pkg.sv
package alu_pkg;
  typedef enum logic [2:0] {
    OP_ADD = 3'd0,
    OP_SUB = 3'd1,
    OP_AND = 3'd2,
    OP_ORR = 3'd3,
    OP_EOR = 3'd4,
    OP_BIC = 3'd5,
    OP_MVN = 3'd6,
    OP_CMP = 3'd7
  } alu_op_e;

  localparam int unsigned FLAG_N = 3;
  localparam int unsigned FLAG_Z = 2;
  localparam int unsigned FLAG_C = 1;
  localparam int unsigned FLAG_V = 0;

  function automatic logic is_logic_op(alu_op_e op);
    return (op inside {OP_AND, OP_ORR, OP_EOR, OP_BIC, OP_MVN});
  endfunction
endpackage

// File: rtl/alu_addsub.sv
module alu_addsub #(
  parameter int unsigned W = 32
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  logic         sub_i,
  output logic [W-1:0] sum_o,
  output logic         carry_o,
  output logic         ovf_o
);
  localparam int unsigned MSB = W - 1;
  logic [W-1:0] b_eff;
  logic [W:0]   wide;

  assign b_eff = sub_i ? ~b_i : b_i;
  assign wide  = {1'b0, a_i} + {1'b0, b_eff} + {{W{1'b0}}, sub_i};
  assign sum_o   = wide[W-1:0];
  assign carry_o = wide[W];
  // signed overflow: like-signed inputs, differently signed output
  assign ovf_o   = (a_i[MSB] == b_eff[MSB]) && (sum_o[MSB] != a_i[MSB]);
endmodule

// File: rtl/alu_logic_unit.sv
module alu_logic_unit
  import alu_pkg::*;
#(
  parameter int unsigned W = 32
) (
  input  alu_op_e      op_i,
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  output logic [W-1:0] res_o
);
  always_comb begin
    unique case (op_i)
      OP_AND:  res_o = a_i & b_i;
      OP_ORR:  res_o = a_i | b_i;
      OP_EOR:  res_o = a_i ^ b_i;
      OP_BIC:  res_o = a_i & ~b_i;
      OP_MVN:  res_o = ~b_i;
      default: res_o = '0;
    endcase
  end
endmodule

// File: rtl/alu_flags_reg.sv
module alu_flags_reg #(
  parameter int unsigned NF = 4
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          we_i,
  input  logic [NF-1:0] d_i,
  output logic [NF-1:0] q_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   q_o <= '0;
    else if (we_i) q_o <= d_i;
  end

  // R7: no enable, no change
  p_hold_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !we_i |=> $stable(q_o));
endmodule

// File: rtl/alu_flag_core.sv
module alu_flag_core
  import alu_pkg::*;
#(
  parameter int unsigned W = 32
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [2:0]   op_i,
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  logic         set_flags_i,
  input  logic         res_en_i,
  output logic [W-1:0] result_o,
  output logic         res_we_o,
  output logic [3:0]   flags_o
);
  localparam int unsigned MSB = W - 1;

  alu_op_e      op;
  logic         is_arith, is_sub, is_cmp, flag_we;
  logic [W-1:0] sum, lres;
  logic         carry, ovf;
  logic [3:0]   flags_d;

  assign op       = alu_op_e'(op_i);
  assign is_cmp   = (op == OP_CMP);
  assign is_sub   = (op == OP_SUB) || is_cmp;
  assign is_arith = (op == OP_ADD) || is_sub;
  assign flag_we  = set_flags_i || is_cmp;

  alu_addsub #(.W(W)) u_addsub (
    .a_i(a_i), .b_i(b_i), .sub_i(is_sub),
    .sum_o(sum), .carry_o(carry), .ovf_o(ovf)
  );

  alu_logic_unit #(.W(W)) u_logic (
    .op_i(op), .a_i(a_i), .b_i(b_i), .res_o(lres)
  );

  assign result_o = is_arith ? sum : lres;
  assign res_we_o = res_en_i && !is_cmp;

  always_comb begin
    flags_d         = flags_o;
    flags_d[FLAG_N] = result_o[MSB];
    flags_d[FLAG_Z] = (result_o == '0);
    if (is_arith) begin
      flags_d[FLAG_C] = carry;
      flags_d[FLAG_V] = ovf;
    end
  end

  alu_flags_reg #(.NF(4)) u_flags (
    .clk_i(clk_i), .rst_ni(rst_ni), .we_i(flag_we),
    .d_i(flags_d), .q_o(flags_o)
  );

  // R6
  p_cmp_no_write_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_i == 3'd7) |-> !res_we_o);
  p_cmp_updates_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_i == 3'd7) |=> (flags_o[FLAG_C] == $past(carry)));
  // R5
  p_logic_keeps_cv_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flag_we && op_i inside {3'd2, 3'd3, 3'd4, 3'd5, 3'd6})
      |=> $stable(flags_o[1:0]));
  // R4
  p_nz_track_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flag_we |=> (flags_o[FLAG_N] == $past(result_o[MSB]))
             && (flags_o[FLAG_Z] == ($past(result_o) == '0)));
  // R8
  p_we_pass_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_i != 3'd7) |-> (res_we_o == res_en_i));
endmodule

// File: tb/alu_flag_core_bench.sv
module alu_flag_core_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [2:0]  op = '0;
  logic [31:0] a = '0, b = '0;
  logic        sf = 1'b0, en = 1'b0;
  logic [31:0] result;
  logic        res_we;
  logic [3:0]  flags;

  int n_chk = 0, n_bad = 0;
  logic [3:0] model_flags = 4'b0;

  always #4 clk = ~clk;

  alu_flag_core u_alu_flag_core (
    .clk_i(clk), .rst_ni(rst_n), .op_i(op), .a_i(a), .b_i(b),
    .set_flags_i(sf), .res_en_i(en), .result_o(result),
    .res_we_o(res_we), .flags_o(flags)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h (op=%0d a=%h b=%h)", req, act, exp, op, a, b);
    end
  endtask

  task automatic step(input logic [2:0] o, input logic [31:0] x, input logic [31:0] y,
                      input logic s, input logic e);
    logic [32:0] w;
    logic [31:0] r, yb;
    logic c, v, arith;
    logic [3:0] nf;
    @(negedge clk);
    op = o; a = x; b = y; sf = s; en = e;
    arith = (o == 3'd0) || (o == 3'd1) || (o == 3'd7);
    yb = (o == 3'd0) ? y : ~y;
    w = {1'b0, x} + {1'b0, yb} + ((o == 3'd0) ? 33'd0 : 33'd1);
    c = w[32];
    v = (x[31] == yb[31]) && (w[31] != x[31]);
    case (o)
      3'd2: r = x & y;
      3'd3: r = x | y;
      3'd4: r = x ^ y;
      3'd5: r = x & ~y;
      3'd6: r = ~y;
      default: r = w[31:0];
    endcase
    #1;
    check(arith ? "R1/R2 result" : "R3 result", result, r);
    check(o == 3'd7 ? "R6 write" : "R8 write", {31'd0, res_we}, {31'd0, (o != 3'd7) && e});
    nf = model_flags;
    if (s || o == 3'd7) begin
      nf[3] = r[31];
      nf[2] = (r == 32'd0);
      if (arith) begin nf[1] = c; nf[0] = v; end
    end
    @(posedge clk); #1;
    model_flags = nf;
    check(o == 3'd7 ? "R6 flags" : (s ? (arith ? "R2/R4 flags" : "R5 flags") : "R7 flags"),
          {28'd0, flags}, {28'd0, nf});
  endtask

  initial begin
    #(8 * 200000);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic [31:0] corner [8];
    logic [31:0] lfsr;
    corner = '{32'h0, 32'h1, 32'h7FFF_FFFF, 32'h8000_0000, 32'hFFFF_FFFF,
               32'h8000_0001, 32'h0000_0017, 32'hF234_012F};
    #3;
    check("R9 reset", {28'd0, flags}, 32'd0);
    rst_n = 1'b1;
    // R10: 17 vs 23
    step(3'd7, 32'd17, 32'd23, 1'b0, 1'b1);
    check("R10 cmp 17-23", {28'd0, flags}, 32'h8);
    for (int o = 0; o < 8; o++)
      for (int i = 0; i < 8; i++)
        for (int j = 0; j < 8; j++)
          for (int k = 0; k < 4; k++)
            step(3'(o), corner[i], corner[j], k[0], k[1]);
    lfsr = 32'hACE1_2468;
    for (int n = 0; n < 3000; n++) begin
      logic [31:0] x, y;
      lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
      x = lfsr;
      lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
      y = (n % 5 == 0) ? x : lfsr;
      step(3'(n % 8), x, y, lfsr[3], lfsr[7]);
    end
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule